// File: doc/BRIEF.md
# Serial Slave Pause Controller

This block handles the pause function of a serial memory slave. It watches three bus pins: an active-low pause request, the serial clock and the active-low chip select. All three are sampled by a fast system clock through a synchroniser chain. From these it decides when the slave's shift logic must stand still, and when the data output must be released to high impedance.

Entry into the paused state and exit from it take effect only while the serial clock is low. If the pause request falls while the clock is high, entry waits for the clock's next low level. Release works the same way. If the slave is deselected while paused, the block raises a one-cycle reset request for the slave logic. It then refuses any new pause until the request pin has been seen high again. A `freeze_o` output gates the bit counter and shift register enables, so the bit position is kept across a pause.

The block carries no data stream of its own. All of its pins are plain level controls, and no valid/ready handshake applies.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `hold_o` and `freeze_o` are 0, `slave_rst_o` is 0, and `dout_oe_o` follows `drive_req_i` while the slave is selected.
- R2: A falling edge on `holdn_i` while `csn_i` is 0 and `sck_i` is 0 enters the paused state (`hold_o`=1).
- R3: A falling edge on `holdn_i` while `sck_i` is 1 and `csn_i` is 0 defers entry until `sck_i` is next 0, provided `holdn_i` is still 0 and `csn_i` still 0.
- R4: While paused, `holdn_i` going to 1 ends the pause once `sck_i` is 0; if `sck_i` is 1 the pause lasts until `sck_i` next goes to 0. If `holdn_i` returns to 0 before that, the pause continues.
- R5: A falling edge on `holdn_i` while `csn_i` is 1 never starts a pause.
- R6: While paused, `freeze_o`=1 and `dout_oe_o`=0 regardless of `drive_req_i`, and toggling `sck_i` has no effect on the paused state.
- R7: `csn_i` going to 1 while paused ends the pause and gives exactly one system-clock cycle of `slave_rst_o`=1.
- R8: After that reset, no pause starts, even on a new selection, until `holdn_i` has been seen at 1. A later falling edge can then start a pause again.
- R9: A deferred entry is cancelled without a reset if `holdn_i` rises or `csn_i` rises before `sck_i` goes low.
- R10: A pin change reaches `hold_o` after exactly SYNC_STAGES+1 rising edges of `clk`, which is 3 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin |
| csn_i | input | 1 | Chip select pin, active low |
| holdn_i | input | 1 | Pause request pin, active low |
| drive_req_i | input | 1 | The slave wants to drive its data output |
| hold_o | output | 1 | Paused state is active |
| freeze_o | output | 1 | Gate for the shift register and bit counter enables |
| dout_oe_o | output | 1 | Data output enable (0 means high impedance) |
| slave_rst_o | output | 1 | One-cycle reset request to the slave logic |

## Verification
Each pin change passes through two synchroniser flops and then one state register. `hold_o` and `slave_rst_o` therefore settle three `clk` edges after the change, and `dout_oe_o` settles within the same window. The bench changes the pins only on a falling edge of `clk` and then waits six cycles. It samples on a falling edge, so every output is read well after its due cycle and before the next stimulus. The reset pulse is counted at every rising edge, so its width is checked exactly and not just its presence. A dedicated run measures the three-edge latency cycle by cycle.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef enum logic [2:0] {
    PS_RUN      = 3'd0,
    PS_ENTERING = 3'd1,
    PS_PAUSED   = 3'd2,
    PS_LEAVING  = 3'd3,
    PS_LOCKED   = 3'd4
  } pause_state_e;

  localparam int PIN_COUNT = 3;
  localparam int PIN_SCK   = 0;
  localparam int PIN_CSN   = 1;
  localparam int PIN_HOLDN = 2;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int          STAGES = 2,
  parameter int          WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d_i;
        else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic csn_s,
  input  logic holdn_s,
  output logic held_o,
  output logic rst_req_o
);
  pause_state_e state_q, state_d;
  logic holdn_prev_q;
  logic holdn_fall;
  logic rst_req_d, rst_req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) holdn_prev_q <= 1'b1;
    else        holdn_prev_q <= holdn_s;
  end

  assign holdn_fall = holdn_prev_q & ~holdn_s;

  always_comb begin
    state_d   = state_q;
    rst_req_d = 1'b0;
    unique case (state_q)
      PS_RUN: begin
        if (holdn_fall && !csn_s) state_d = sck_s ? PS_ENTERING : PS_PAUSED;
      end
      PS_ENTERING: begin
        if (csn_s || holdn_s) state_d = PS_RUN;
        else if (!sck_s)      state_d = PS_PAUSED;
      end
      PS_PAUSED: begin
        if (csn_s) begin
          state_d   = PS_LOCKED;
          rst_req_d = 1'b1;
        end else if (holdn_s) begin
          state_d = sck_s ? PS_LEAVING : PS_RUN;
        end
      end
      PS_LEAVING: begin
        if (csn_s) begin
          state_d   = PS_LOCKED;
          rst_req_d = 1'b1;
        end else if (!holdn_s) state_d = PS_PAUSED;
        else if (!sck_s)       state_d = PS_RUN;
      end
      PS_LOCKED: begin
        if (holdn_s) state_d = PS_RUN;
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_RUN;
      rst_req_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rst_req_q <= rst_req_d;
    end
  end

  assign held_o    = (state_q == PS_PAUSED) || (state_q == PS_LEAVING);
  assign rst_req_o = rst_req_q;

  AST_ENTRY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_o) |-> ($past(sck_s) == 1'b0)) else $error("entry with clock high"); // R3
  AST_ENTRY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_o) |-> ($past(csn_s) == 1'b0)) else $error("entry while deselected"); // R5
  AST_EXIT_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(held_o) && !rst_req_o) |-> ($past(sck_s) == 1'b0)) else $error("exit with clock high"); // R4
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o) else $error("reset pulse too long"); // R7
  AST_RST_FROM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(held_o)) else $error("reset without pause"); // R7
  AST_LOCK_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !held_o) else $error("pause right after reset"); // R8
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic holdn_i,
  input  logic drive_req_i,
  output logic hold_o,
  output logic freeze_o,
  output logic dout_oe_o,
  output logic slave_rst_o
);
  localparam logic [PIN_COUNT-1:0] PIN_RST = (1 << PIN_CSN) | (1 << PIN_HOLDN);

  logic [PIN_COUNT-1:0] pins_raw, pins_s;
  logic held;

  assign pins_raw[PIN_SCK]   = sck_i;
  assign pins_raw[PIN_CSN]   = csn_i;
  assign pins_raw[PIN_HOLDN] = holdn_i;

  hold_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (PIN_COUNT),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pins_raw),
    .q_o  (pins_s)
  );

  hold_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (pins_s[PIN_SCK]),
    .csn_s    (pins_s[PIN_CSN]),
    .holdn_s  (pins_s[PIN_HOLDN]),
    .held_o   (held),
    .rst_req_o(slave_rst_o)
  );

  assign hold_o    = held;
  assign freeze_o  = held;
  assign dout_oe_o = drive_req_i & ~pins_s[PIN_CSN] & ~held;

  AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && pins_s[PIN_CSN]) |=> !hold_o) else $error("pause kept after deselect"); // R7
endmodule

// File: tb/spi_hold_ctrl_bench.sv
module spi_hold_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, holdn = 1'b1, drv = 1'b1;
  logic hold, freeze, oe, srst;

  int total = 0, bad = 0;
  int rst_cycles = 0;
  int m_st = 0;          // 0 run,1 entering,2 paused,3 leaving,4 locked
  int m_rst = 0;
  logic m_prev_h = 1'b1;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_hold_ctrl u_spi_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .holdn_i(holdn),
    .drive_req_i(drv), .hold_o(hold), .freeze_o(freeze), .dout_oe_o(oe),
    .slave_rst_o(srst)
  );

  always @(posedge clk) if (srst) rst_cycles++;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model(input logic s, input logic c, input logic h);
    bit fall = m_prev_h && !h;
    for (int i = 0; i < 3; i++) begin
      case (m_st)
        0: if (fall && !c) m_st = s ? 1 : 2;
        1: if (c || h) m_st = 0; else if (!s) m_st = 2;
        2: if (c) begin m_st = 4; m_rst++; end else if (h) m_st = s ? 3 : 0;
        3: if (c) begin m_st = 4; m_rst++; end else if (!h) m_st = 2; else if (!s) m_st = 0;
        default: if (h) m_st = 0;
      endcase
      fall = 1'b0;
    end
    m_prev_h = h;
  endtask

  task automatic step(input logic s, input logic c, input logic h, input logic d, input string req);
    int held_exp;
    @(negedge clk);
    sck = s; csn = c; holdn = h; drv = d;
    model(s, c, h);
    repeat (6) @(negedge clk);
    held_exp = (m_st == 2 || m_st == 3) ? 1 : 0;
    chk({req, " hold"}, int'(hold), held_exp);
    chk({req, " freeze"}, int'(freeze), held_exp);
    chk({req, " oe"}, int'(oe), (d && !c && held_exp == 0) ? 1 : 0);
    chk({req, " rst_count"}, rst_cycles, m_rst);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 hold", int'(hold), 0);
    chk("R1 rst", int'(srst), 0);
    rst_n = 1'b1;
    step(0, 0, 1, 1, "R1");
    step(0, 0, 0, 1, "R2 enter");
    step(1, 0, 0, 1, "R6 sck high");
    step(0, 0, 0, 0, "R6 sck low");
    step(1, 0, 1, 1, "R4 defer exit");
    step(1, 0, 0, 1, "R4 reassert");
    step(0, 0, 1, 1, "R4 exit");
    step(1, 0, 0, 1, "R3 defer entry");
    step(0, 0, 0, 1, "R3 enter");
    step(0, 1, 0, 1, "R7 deselect");
    step(0, 0, 0, 1, "R8 blocked");
    step(0, 0, 1, 1, "R8 release");
    step(0, 0, 0, 1, "R8 rehold");
    step(0, 0, 1, 1, "R4 out");
    step(0, 1, 0, 1, "R5 deselected fall");
    step(0, 0, 0, 1, "R5 select low");
    step(0, 0, 1, 1, "R5 clean");
    step(1, 0, 0, 1, "R9 pend");
    step(1, 0, 1, 1, "R9 cancel by hold");
    step(1, 0, 0, 1, "R9 pend2");
    step(1, 1, 0, 1, "R9 cancel by cs");
    step(0, 0, 1, 1, "R9 clean");
    // R10: latency of entry
    @(negedge clk);
    holdn = 1'b0; model(sck, csn, 1'b0);
    lat = 0;
    while (!hold && lat < 10) begin @(posedge clk); lat++; #1; end
    chk("R10 latency", lat, 3);
    step(0, 0, 1, 1, "R10 clean");
    // near-exhaustive sweep of three-step pin sequences
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++) begin
          step(0, 0, 1, 1, "R4 sweep base");
          step(a[0], a[1], a[2], b[0], "R6 sweep a");
          step(b[0], b[1], b[2], c[1], "R7 sweep b");
          step(c[0], c[1], c[2], a[1], "R8 sweep c");
        end
    finished = 1'b1;
  end

  initial begin
    for (int n = 0; n < 190000 && !finished; n++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=0 exp=1");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule